// File: doc/BRIEF.md
# Programmable Raster Timing Generator

The block produces the horizontal sync, vertical sync and data-enable strobes of a raster display, together with the current pixel coordinates. It also passes a pixel stream through to the display, blanked outside the visible area. Each axis is built from four segments in a fixed order: visible data, front porch, sync pulse, back porch. Software programs every segment as its length minus one. A line is the sum of the four horizontal segments, in pixel clocks. A frame is the sum of the four vertical segments, in lines.

A small register port sets the segment lengths, the run command, the active level of each output, and a maskable interrupt. The interrupt is raised when vertical sync begins. Segment lengths that software writes while the generator runs are held in shadow registers. They are copied into use only at the frame boundary, so a frame is never torn. The pixel fetch and the pixel clock lie outside the block.

Top module: `vtg_top`

## Requirements
- R1: After reset the run command, polarity, mask and status registers read 0. The outputs are hsync_o=1, vsync_o=1, de_o=1, pix_o all ones, x_o=0, y_o=0 and irq_o=0.
- R2: Register addresses are: 0 run command (bit 0), 1 polarity, 2 interrupt mask (bit 0), 3 interrupt status (bit 0), 4..7 horizontal visible/front porch/sync/back porch, 8..11 vertical in the same order. A timing register reads back the last value written to it.
- R3: A line lasts (A+1)+(F+1)+(S+1)+(B+1) cycles, where A, F, S and B are the programmed horizontal values. The segments run in the order visible, front porch, sync, back porch. x_o counts 0 up to the line total minus 1. hsync_o is asserted exactly while x_o lies in the sync segment.
- R4: y_o advances by one when x_o wraps and counts frame lines with the same segment rule applied to the vertical values. vsync_o is asserted for the whole lines of the vertical sync segment.
- R5: de_o is asserted only when x_o and y_o are both inside their visible segments and the generator runs.
- R6: Polarity bit 0 (hsync), bit 1 (vsync), bit 2 (data enable) and bit 3 (data) each select an active-high level when set, and active-low when clear. pix_o is the pix_in value from one cycle earlier inside the visible area, and zero outside it. When bit 3 is clear, the whole word is inverted.
- R7: Writing 1 to the run command makes the outputs show coordinate (0,0) after the second rising edge, counting the write edge as the first. Writing 0 returns x_o and y_o to 0 and every strobe to its inactive level after the second rising edge.
- R8: A timing write made while running takes effect from the first line of the next frame. A write made while stopped is used from the first frame after start.
- R9: The status bit sets when the outputs first show vertical sync in a frame. It stays set until 1 is written to it. Writing 0 leaves it unchanged. A set that falls in the same cycle as a clear wins.
- R10: irq_o is high exactly when the status bit and the mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for both read and write |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Read data for reg_addr, combinational |
| pix_in | input | PIX_W | Pixel value for the current counter position |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_o | output | PIX_W | Pixel data to the display |
| x_o | output | CNT_W+2 | Horizontal position of the current output cycle |
| y_o | output | CNT_W+2 | Vertical position of the current output cycle |
| irq_o | output | 1 | Vertical sync interrupt |

## Verification
Every strobe, the pixel word and both coordinates are registered. Each one describes the counter position that held before the latest rising edge, so it is due one edge after the position is reached. A register write is due one edge after its write strobe. The start and stop of scanning are due two edges after the write strobe. The status bit and irq_o change on the same edge as the first vsync_o cycle of a frame. A reference model in the bench steps on every rising edge, using the input values present before that edge, and queues the output vector it expects after the edge. A monitor removes one entry on each falling edge and compares it, so every expectation is sampled half a cycle after the edge that is due to produce it. Directed checks that count data-enable runs or read registers also sample on falling edges, after writes the bench drove there.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    localparam int unsigned ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_RUN   = 4'd0,
        RA_POL   = 4'd1,
        RA_MASK  = 4'd2,
        RA_STAT  = 4'd3,
        RA_H_VIS = 4'd4,
        RA_H_FP  = 4'd5,
        RA_H_SYN = 4'd6,
        RA_H_BP  = 4'd7,
        RA_V_VIS = 4'd8,
        RA_V_FP  = 4'd9,
        RA_V_SYN = 4'd10,
        RA_V_BP  = 4'd11
    } reg_addr_e;

    // polarity bit positions
    localparam int unsigned PB_HS   = 0;
    localparam int unsigned PB_VS   = 1;
    localparam int unsigned PB_DE   = 2;
    localparam int unsigned PB_DATA = 3;
    localparam int unsigned POL_W   = 4;

    // segment slot order inside an axis (behavioural order)
    localparam int unsigned SEG_VIS = 0;
    localparam int unsigned SEG_FP  = 1;
    localparam int unsigned SEG_SYN = 2;
    localparam int unsigned SEG_BP  = 3;
    localparam int unsigned N_SEG   = 4;

endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
    import vtg_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [CNT_W-1:0]                  wdata,
    input  logic                              frame_end,
    input  logic                              vs_event,
    output logic [CNT_W-1:0]                  rdata,
    output logic                              run,
    output logic [POL_W-1:0]                  pol,
    output logic                              mask,
    output logic                              stat,
    output logic [N_SEG-1:0][CNT_W-1:0]       h_live,
    output logic [N_SEG-1:0][CNT_W-1:0]       v_live
);

    typedef struct packed {
        logic                        run;
        logic [POL_W-1:0]            pol;
        logic                        mask;
        logic                        stat;
        logic [N_SEG-1:0][CNT_W-1:0] h_sh;
        logic [N_SEG-1:0][CNT_W-1:0] v_sh;
        logic [N_SEG-1:0][CNT_W-1:0] h_lv;
        logic [N_SEG-1:0][CNT_W-1:0] v_lv;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    clr_hit;

    always_comb begin
        st_d    = st_q;
        clr_hit = we && (addr == RA_STAT) && wdata[0];

        // shadow to live: while stopped, or on the last pixel of a frame
        if (!st_q.run || frame_end) begin
            st_d.h_lv = st_q.h_sh;
            st_d.v_lv = st_q.v_sh;
        end

        // sticky status, set beats clear
        if (vs_event) begin
            st_d.stat = 1'b1;
        end else if (clr_hit) begin
            st_d.stat = 1'b0;
        end

        if (we) begin
            case (reg_addr_e'(addr))
                RA_RUN:  st_d.run  = wdata[0];
                RA_POL:  st_d.pol  = wdata[POL_W-1:0];
                RA_MASK: st_d.mask = wdata[0];
                RA_H_VIS, RA_H_FP, RA_H_SYN, RA_H_BP:
                    st_d.h_sh[addr[1:0]] = wdata;
                RA_V_VIS, RA_V_FP, RA_V_SYN, RA_V_BP:
                    st_d.v_sh[addr[1:0]] = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_addr_e'(addr))
            RA_RUN:  rdata[0] = st_q.run;
            RA_POL:  rdata[POL_W-1:0] = st_q.pol;
            RA_MASK: rdata[0] = st_q.mask;
            RA_STAT: rdata[0] = st_q.stat;
            RA_H_VIS, RA_H_FP, RA_H_SYN, RA_H_BP:
                rdata = st_q.h_sh[addr[1:0]];
            RA_V_VIS, RA_V_FP, RA_V_SYN, RA_V_BP:
                rdata = st_q.v_sh[addr[1:0]];
            default: rdata = '0;
        endcase
    end

    assign run    = st_q.run;
    assign pol    = st_q.pol;
    assign mask   = st_q.mask;
    assign stat   = st_q.stat;
    assign h_live = st_q.h_lv;
    assign v_live = st_q.v_lv;

endmodule

// File: rtl/vtg_axis.sv
module vtg_axis
    import vtg_pkg::*;
#(
    parameter int unsigned CNT_W = 12,
    localparam int unsigned POS_W = CNT_W + 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        run,
    input  logic                        step,
    input  logic [N_SEG-1:0][CNT_W-1:0] seg_len,
    output logic [POS_W-1:0]            pos,
    output logic                        last,
    output logic                        in_vis,
    output logic                        in_sync,
    output logic                        sync_first
);

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } ax_st_t;

    ax_st_t st_d, st_q;
    // seg_end[k] is the last position inside segment k
    logic [N_SEG-1:0][POS_W-1:0] seg_end;

    always_comb begin
        seg_end[SEG_VIS] = POS_W'(seg_len[SEG_VIS]);
        for (int k = 1; k < N_SEG; k++) begin
            seg_end[k] = seg_end[k-1] + POS_W'(seg_len[k]) + POS_W'(1);
        end
    end

    always_comb begin
        last       = (st_q.pos == seg_end[SEG_BP]);
        in_vis     = (st_q.pos <= seg_end[SEG_VIS]);
        in_sync    = (st_q.pos > seg_end[SEG_FP]) && (st_q.pos <= seg_end[SEG_SYN]);
        sync_first = (st_q.pos == seg_end[SEG_FP] + POS_W'(1));

        st_d = st_q;
        if (!run) begin
            st_d.pos = '0;
        end else if (step) begin
            st_d.pos = last ? '0 : st_q.pos + POS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos = st_q.pos;

endmodule

// File: rtl/vtg_top.sv
module vtg_top
    import vtg_pkg::*;
#(
    parameter int unsigned CNT_W = 12,
    parameter int unsigned PIX_W = 24,
    localparam int unsigned POS_W = CNT_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [CNT_W-1:0]   reg_wdata,
    output logic [CNT_W-1:0]   reg_rdata,
    input  logic [PIX_W-1:0]   pix_in,
    output logic               hsync_o,
    output logic               vsync_o,
    output logic               de_o,
    output logic [PIX_W-1:0]   pix_o,
    output logic [POS_W-1:0]   x_o,
    output logic [POS_W-1:0]   y_o,
    output logic               irq_o
);

    localparam int unsigned N_AX = 2;   // 0 horizontal, 1 vertical

    typedef struct packed {
        logic             hs;
        logic             vs;
        logic             de;
        logic [PIX_W-1:0] pix;
        logic [POS_W-1:0] x;
        logic [POS_W-1:0] y;
    } out_t;

    localparam out_t OUT_RST = '{hs: 1'b1, vs: 1'b1, de: 1'b1, pix: '1, x: '0, y: '0};

    logic                              ctrl_run;
    logic [POL_W-1:0]                  pol_bits;
    logic                              irq_mask;
    logic                              irq_stat;
    logic [N_SEG-1:0][CNT_W-1:0]       h_live, v_live;
    logic [N_AX-1:0][N_SEG-1:0][CNT_W-1:0] ax_len;
    logic [N_AX-1:0][POS_W-1:0]        ax_pos;
    logic [N_AX-1:0]                   ax_step, ax_last, ax_vis, ax_sync, ax_sfirst;
    logic                              frame_end, vs_event, vis_now;
    logic                              unused_h_sfirst;
    out_t                              out_d, out_q;

    vtg_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .frame_end (frame_end),
        .vs_event  (vs_event),
        .rdata     (reg_rdata),
        .run       (ctrl_run),
        .pol       (pol_bits),
        .mask      (irq_mask),
        .stat      (irq_stat),
        .h_live    (h_live),
        .v_live    (v_live)
    );

    assign ax_len[0]  = h_live;
    assign ax_len[1]  = v_live;
    assign ax_step[0] = 1'b1;
    assign ax_step[1] = ax_last[0];

    for (genvar g = 0; g < N_AX; g++) begin : g_axis
        vtg_axis #(.CNT_W(CNT_W)) u_axis (
            .clk        (clk),
            .rst_n      (rst_n),
            .run        (ctrl_run),
            .step       (ax_step[g]),
            .seg_len    (ax_len[g]),
            .pos        (ax_pos[g]),
            .last       (ax_last[g]),
            .in_vis     (ax_vis[g]),
            .in_sync    (ax_sync[g]),
            .sync_first (ax_sfirst[g])
        );
    end

    assign unused_h_sfirst = ax_sfirst[0];

    assign frame_end = ctrl_run && ax_last[0] && ax_last[1];
    assign vs_event  = ctrl_run && ax_sfirst[1] && (ax_pos[0] == '0);
    assign vis_now   = ctrl_run && ax_vis[0] && ax_vis[1];

    always_comb begin
        out_d.hs  = (ctrl_run && ax_sync[0]) ? pol_bits[PB_HS] : !pol_bits[PB_HS];
        out_d.vs  = (ctrl_run && ax_sync[1]) ? pol_bits[PB_VS] : !pol_bits[PB_VS];
        out_d.de  = vis_now ? pol_bits[PB_DE] : !pol_bits[PB_DE];
        out_d.pix = (vis_now ? pix_in : '0) ^ {PIX_W{!pol_bits[PB_DATA]}};
        out_d.x   = ctrl_run ? ax_pos[0] : '0;
        out_d.y   = ctrl_run ? ax_pos[1] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= OUT_RST;
        end else begin
            out_q <= out_d;
        end
    end

    assign hsync_o = out_q.hs;
    assign vsync_o = out_q.vs;
    assign de_o    = out_q.de;
    assign pix_o   = out_q.pix;
    assign x_o     = out_q.x;
    assign y_o     = out_q.y;
    assign irq_o   = irq_stat && irq_mask;

endmodule

// File: rtl/vtg_chk.sv
module vtg_chk #(
    parameter int unsigned POS_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic [3:0]       pol,
    input logic             stat,
    input logic             we,
    input logic [3:0]       addr,
    input logic             wd0,
    input logic [POS_W-1:0] x,
    input logic [POS_W-1:0] y,
    input logic             vs,
    input logic             de
);

    // R7: a stopped generator parks at the origin on the next edge
    p_idle_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (x == '0 && y == '0));

    // R3: the horizontal position steps by one or wraps to zero
    p_x_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (x == POS_W'($past(x) + 1'b1) || x == '0));

    // R4: the vertical position holds, steps by one, or wraps
    p_y_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (y == $past(y) || y == POS_W'($past(y) + 1'b1) || y == '0));

    // R4: the line changes only together with a horizontal wrap
    p_y_on_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (y != $past(y)) |-> (x == '0));

    // R9: status is sticky unless a 1 is written to it
    p_stat_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat && !(we && addr == 4'd3 && wd0)) |=> stat);

    // R9: status rises together with the vsync output
    p_stat_with_vsync_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat) |-> (vs == $past(pol[1])));

    // R5: data enable is asserted only while running
    p_de_needs_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (de == $past(pol[2])) |-> $past(run));

endmodule

bind vtg_top vtg_chk #(.POS_W(POS_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (ctrl_run),
    .pol   (pol_bits),
    .stat  (irq_stat),
    .we    (reg_we),
    .addr  (reg_addr),
    .wd0   (reg_wdata[0]),
    .x     (x_o),
    .y     (y_o),
    .vs    (vsync_o),
    .de    (de_o)
);

// File: tb/sim_vtg_top.sv
`timescale 1ns/1ps
module sim_vtg_top;

    localparam int CW = 12;
    localparam int PW = 24;
    localparam int QW = CW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [CW-1:0] reg_wdata = '0;
    logic [CW-1:0] reg_rdata;
    logic [PW-1:0] pix_in = '0;
    logic          hsync_o, vsync_o, de_o, irq_o;
    logic [PW-1:0] pix_o;
    logic [QW-1:0] x_o, y_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    vtg_top #(.CNT_W(CW), .PIX_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_in(pix_in),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pix_o(pix_o),
        .x_o(x_o), .y_o(y_o), .irq_o(irq_o)
    );

    typedef struct packed {
        logic          hs;
        logic          vs;
        logic          de;
        logic [PW-1:0] pix;
        logic [QW-1:0] x;
        logic [QW-1:0] y;
        logic          irq;
    } exp_t;

    exp_t exp_q[$];

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- reference model (requirements view) ----------------
    bit       m_run, m_mask, m_stat;
    bit [3:0] m_pol;
    int       m_x, m_y;
    int       hs_sh[4], vs_sh[4], hs_lv[4], vs_lv[4];

    function automatic int seg_of(input int p, input int a, input int f, input int s);
        if (p <= a) return 0;
        if (p <= a + f + 1) return 1;
        if (p <= a + f + s + 2) return 2;
        return 3;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_mask = 0; m_stat = 0; m_pol = '0; m_x = 0; m_y = 0;
            for (int k = 0; k < 4; k++) begin
                hs_sh[k] = 0; vs_sh[k] = 0; hs_lv[k] = 0; vs_lv[k] = 0;
            end
        end else begin
            exp_t e;
            int hseg, vseg, htot, vtot;
            bit vis, setv, clrv, fend;
            hseg = seg_of(m_x, hs_lv[0], hs_lv[1], hs_lv[2]);
            vseg = seg_of(m_y, vs_lv[0], vs_lv[1], vs_lv[2]);
            htot = hs_lv[0] + hs_lv[1] + hs_lv[2] + hs_lv[3] + 4;
            vtot = vs_lv[0] + vs_lv[1] + vs_lv[2] + vs_lv[3] + 4;
            vis  = m_run && hseg == 0 && vseg == 0;
            e.hs  = (m_run && hseg == 2) ? m_pol[0] : !m_pol[0];
            e.vs  = (m_run && vseg == 2) ? m_pol[1] : !m_pol[1];
            e.de  = vis ? m_pol[2] : !m_pol[2];
            e.pix = (vis ? pix_in : '0) ^ {PW{!m_pol[3]}};
            e.x   = m_run ? QW'(m_x) : '0;
            e.y   = m_run ? QW'(m_y) : '0;
            setv = m_run && m_x == 0 && m_y == vs_lv[0] + vs_lv[1] + 2;
            clrv = reg_we && reg_addr == 4'd3 && reg_wdata[0];
            fend = m_run && m_x == htot - 1 && m_y == vtot - 1;
            if (!m_run) begin
                m_x = 0; m_y = 0;
            end else if (m_x == htot - 1) begin
                m_x = 0;
                m_y = (m_y == vtot - 1) ? 0 : m_y + 1;
            end else begin
                m_x = m_x + 1;
            end
            if (!m_run || fend) begin
                for (int k = 0; k < 4; k++) begin
                    hs_lv[k] = hs_sh[k]; vs_lv[k] = vs_sh[k];
                end
            end
            if (setv) m_stat = 1;
            else if (clrv) m_stat = 0;
            if (reg_we) begin
                case (reg_addr)
                    4'd0: m_run  = reg_wdata[0];
                    4'd1: m_pol  = reg_wdata[3:0];
                    4'd2: m_mask = reg_wdata[0];
                    4'd4, 4'd5, 4'd6, 4'd7:   hs_sh[reg_addr[1:0]] = int'(reg_wdata);
                    4'd8, 4'd9, 4'd10, 4'd11: vs_sh[reg_addr[1:0]] = int'(reg_wdata);
                    default: ;
                endcase
            end
            e.irq = m_stat && m_mask;
            exp_q.push_back(e);
        end
    end

    // ---------------- monitor ----------------
    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            exp_t g;
            g = exp_q.pop_front();
            check("R3", "hsync", 64'(hsync_o), 64'(g.hs));
            check("R3", "x", 64'(x_o), 64'(g.x));
            check("R4", "vsync", 64'(vsync_o), 64'(g.vs));
            check("R4", "y", 64'(y_o), 64'(g.y));
            check("R5", "de", 64'(de_o), 64'(g.de));
            check("R6", "pix", 64'(pix_o), 64'(g.pix));
            check("R10", "irq", 64'(irq_o), 64'(g.irq));
        end
    end

    // ---------------- driver ----------------
    task automatic wr(input logic [3:0] a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = CW'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input int exp);
        reg_addr = a;
        #1;
        check(req, "rdata", 64'(reg_rdata), 64'(exp));
    endtask

    task automatic wait_xy(input int x, input int y);
        do @(negedge clk); while (!(x_o == QW'(x) && y_o == QW'(y)));
    endtask

    task automatic de_run(output int n);
        n = 0;
        while (de_o) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin : pix_gen
        forever begin
            @(negedge clk);
            pix_in = pix_in + 24'h010203;
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "hsync", 64'(hsync_o), 64'h1);
        check("R1", "vsync", 64'(vsync_o), 64'h1);
        check("R1", "de", 64'(de_o), 64'h1);
        check("R1", "pix", 64'(pix_o), 64'hFFFFFF);
        check("R1", "xy", 64'({x_o, y_o}), 64'h0);
        check("R1", "irq", 64'(irq_o), 64'h0);
        rd_chk("R1", 4'd0, 0);
        rd_chk("R1", 4'd3, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // program timing while stopped: H 8/2/3/2, V 4/1/2/1
        wr(4'd4, 7); wr(4'd5, 1); wr(4'd6, 2); wr(4'd7, 1);
        wr(4'd8, 3); wr(4'd9, 0); wr(4'd10, 1); wr(4'd11, 0);
        wr(4'd1, 4'b0111); wr(4'd2, 1);
        rd_chk("R2", 4'd4, 7);
        rd_chk("R2", 4'd6, 2);
        rd_chk("R2", 4'd8, 3);
        rd_chk("R2", 4'd1, 7);
        rd_chk("R2", 4'd2, 1);

        // R7 start
        wr(4'd0, 1);
        @(negedge clk);
        check("R7", "start xy", 64'({x_o, y_o}), 64'h0);
        check("R7", "start de", 64'(de_o), 64'h1);

        // R9 status set and W1C, R10 gating
        do @(negedge clk); while (!irq_o);
        check("R9", "vsync at status set", 64'(vsync_o), 64'h1);
        check("R9", "status set line", 64'(y_o), 64'd5);
        rd_chk("R9", 4'd3, 1);
        wr(4'd3, 1);
        rd_chk("R9", 4'd3, 0);
        do @(negedge clk); while (!irq_o);
        wr(4'd3, 0);
        rd_chk("R9", 4'd3, 1);
        wr(4'd2, 0);
        check("R10", "masked irq", 64'(irq_o), 64'h0);
        wr(4'd2, 1);
        check("R10", "unmasked irq", 64'(irq_o), 64'h1);
        wr(4'd3, 1);

        // R8 mid-frame timing write
        wait_xy(3, 0);
        wr(4'd4, 5);
        wait_xy(0, 1);
        de_run(n);
        check("R8", "old visible width", 64'(n), 64'd8);
        wait_xy(0, 0);
        de_run(n);
        check("R8", "new visible width", 64'(n), 64'd6);

        // R6 polarity flip for a frame (model compares)
        wr(4'd1, 4'b1000);
        repeat (120) @(negedge clk);
        wr(4'd1, 4'b0111);

        // R7 stop
        wr(4'd0, 0);
        @(negedge clk);
        check("R7", "stop xy", 64'({x_o, y_o}), 64'h0);
        check("R7", "stop hsync", 64'(hsync_o), 64'h0);
        check("R7", "stop de", 64'(de_o), 64'h0);

        // R8 write while stopped, then restart
        wr(4'd8, 1);
        wr(4'd0, 1);
        @(negedge clk);
        repeat (3) wait_xy(0, 0);
        n = 0;
        for (int i = 0; i < 13 * 6; i++) begin
            if (de_o) n++;
            @(negedge clk);
        end
        check("R8", "visible cycles per frame after restart", 64'(n), 64'd12);

        repeat (5) @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule